// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight external interrupt request pins. Each pin passes through a synchroniser. A detector then looks for the condition that software picked for that pin: a rising edge, a falling edge, either edge, a low level or a high level. When the condition is seen, the pin's pending flag is latched. Each flag is gated by a per-pin mask bit and by a per-pin priority field, where a zero field disables the pin. The block drives one interrupt line per pin and a combined line that is the OR of all of them.

Software reaches the block through a simple synchronous register bus with five word registers.

- Sense and priority are read-write. They hold 4-bit fields; the sense field width can be set to 2 bits at build time. They read back exactly what was written, so a driver can change one field by read-modify-write.
- Pending flags are read from the source register. Writing a 0 to a pending bit clears it, and writing a 1 leaves it alone.
- Masking uses two write-only registers. A 1 written to the set register masks a pin, and a 1 written to the clear register unmasks it.
- In every register, pin 0 occupies the most significant field or bit.

Top module: `extint_pin_ctrl`

## Requirements
- R1: Reset state. After reset, all mask bits are set, all priority and sense fields are 0, all pending flags are 0, `irq_out` and `irq_any` are 0, and `bus_rdata` is 0.
- R2: Pin timing. A pin level first sampled at rising edge k sets the pending flag at edge k+2. The pin goes through two synchroniser flops, and an edge is found by comparing the synchronised value with its value one clock earlier.
- R3: Edge sense codes. Code 0 is a falling edge, code 1 is a rising edge and code 4 is either edge. An edge of the other polarity causes no event.
- R4: Level sense codes. Code 2 is a low level and code 3 is a high level. While the level is active the pending flag is set on every clock, so a clear write takes effect only once the synchronised level has gone away.
- R5: Codes 5 to 15 never set a pending flag.
- R6: Sense register layout. The sense register is at word address 0. Pin n's field occupies bits [32-(n+1)*W +: W], with W = 4. The field bits read back exactly as written, and bits outside all fields read 0.
- R7: Priority register layout. The priority register is at address 1 and has a 4-bit field per pin, with pin 0 in bits 31:28. It reads back exactly as written. A zero field holds that pin's `irq_out` at 0, and a nonzero field lets it through.
- R8: Source register. The source register is at address 2, with pin n at bit 7-n. A write clears each pending flag whose bit is written as 0 and keeps each flag whose bit is written as 1. An event in the same cycle wins over the clear.
- R9: Mask registers. Writing address 3 sets the mask of each pin whose bit 7-n is 1. Writing address 4 clears the mask of each pin whose bit 7-n is 1. Zero bits have no effect, and both addresses read 0.
- R10: Outputs. `irq_out[n]` = pending AND NOT mask AND (priority field != 0), and `irq_any` is the OR of all `irq_out` bits.
- R11: Read timing and decoding. A read with `bus_rd_en` loads `bus_rdata` at that clock edge, and `bus_rdata` holds its value until the next read. Addresses 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | External request pins, bit n is pin n |
| irq_out | output | 8 | Per-pin interrupt, bit n is pin n |
| irq_any | output | 1 | OR of all per-pin interrupts |

## Verification
A pending flag that is set wrongly, or lost, shows on `irq_out` in the same cycle whenever the pin is unmasked and has a nonzero priority. When the pin is masked, the fault is seen on the next source-register read, one clock after the read strobe. A corrupted sense, priority or mask value can stay hidden until the pin's next edge or level change. For that reason the reference model is compared on every clock, while pins move in each sense mode, and each register is read back after it is written. The synchroniser depth is pinned down by checking the exact edge at which the first interrupt appears after a pin change.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int REG_W = 32;

  localparam int ADDR_SENSE = 0;
  localparam int ADDR_PRIO  = 1;
  localparam int ADDR_SRC   = 2;
  localparam int ADDR_MSET  = 3;
  localparam int ADDR_MCLR  = 4;

  typedef enum logic [2:0] {
    SNS_FALL = 3'd0,
    SNS_RISE = 3'd1,
    SNS_LOW  = 3'd2,
    SNS_HIGH = 3'd3,
    SNS_BOTH = 3'd4
  } sense_e;

  // lowest bit of pin n's field; pin 0 owns the top field
  function automatic int field_lsb(int pin, int fw);
    return REG_W - (pin + 1) * fw;
  endfunction

  // bit of pin n in the one-bit-per-pin registers
  function automatic int pin_bit(int pin, int bw);
    return bw - 1 - pin;
  endfunction

  // bits covered by the fields of np pins
  function automatic logic [REG_W-1:0] field_mask(int np, int fw);
    logic [REG_W-1:0] m;
    m = '0;
    for (int n = 0; n < np; n++)
      for (int b = 0; b < fw; b++)
        m[field_lsb(n, fw) + b] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], pin};
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
#(
  parameter int SW = 4
) (
  input  logic [SW-1:0] code,
  input  logic          lvl,
  input  logic          rise,
  input  logic          fall,
  output logic          evt
);
  logic [7:0] wide;

  always_comb begin
    wide = 8'(code);
    evt  = 1'b0;
    if (wide <= 8'd4) begin
      case (sense_e'(wide[2:0]))
        SNS_FALL: evt = fall;
        SNS_RISE: evt = rise;
        SNS_LOW:  evt = ~lvl;
        SNS_HIGH: evt = lvl;
        SNS_BOTH: evt = rise | fall;
        default:  evt = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int NP   = 8,
  parameter int SW   = 4,
  parameter int PW   = 4,
  parameter int SRCW = 8,
  parameter int AW   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [REG_W-1:0] wdata,
  input  logic [NP-1:0]    evt,
  output logic [REG_W-1:0] rdata,
  output logic [NP*SW-1:0] sense_fld,
  output logic [NP-1:0]    prio_on,
  output logic [NP-1:0]    mask_vec,
  output logic [NP-1:0]    pend_vec,
  output logic             src_wr,
  output logic [NP-1:0]    keep_vec,
  output logic [NP-1:0]    mset_vec,
  output logic [NP-1:0]    mclr_vec
);
  localparam logic [REG_W-1:0] SENSE_KEEP = field_mask(NP, SW);
  localparam logic [REG_W-1:0] PRIO_KEEP  = field_mask(NP, PW);

  logic [REG_W-1:0] sense_q, prio_q, rd_mux;
  logic [NP-1:0]    pend_q, mask_q;
  logic [SRCW-1:0]  src_view;
  logic             wr_sense, wr_prio, wr_mset, wr_mclr;

  assign wr_sense = wr_en && (addr == AW'(ADDR_SENSE));
  assign wr_prio  = wr_en && (addr == AW'(ADDR_PRIO));
  assign src_wr   = wr_en && (addr == AW'(ADDR_SRC));
  assign wr_mset  = wr_en && (addr == AW'(ADDR_MSET));
  assign wr_mclr  = wr_en && (addr == AW'(ADDR_MCLR));

  for (genvar n = 0; n < NP; n++) begin : g_pin
    localparam int SB = pin_bit(n, SRCW);
    localparam int SL = field_lsb(n, SW);
    localparam int PL = field_lsb(n, PW);
    assign keep_vec[n] = src_wr ? wdata[SB] : 1'b1;
    assign mset_vec[n] = wr_mset & wdata[SB];
    assign mclr_vec[n] = wr_mclr & wdata[SB];
    assign prio_on[n]  = |prio_q[PL +: PW];
    assign sense_fld[n*SW +: SW] = sense_q[SL +: SW];
    assign src_view[SB] = pend_q[n];
  end

  for (genvar b = NP; b < SRCW; b++) begin : g_unused
    assign src_view[pin_bit(b, SRCW)] = 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (addr == AW'(ADDR_SENSE))     rd_mux = sense_q;
    else if (addr == AW'(ADDR_PRIO)) rd_mux = prio_q;
    else if (addr == AW'(ADDR_SRC))  rd_mux = REG_W'(src_view);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      prio_q  <= '0;
      pend_q  <= '0;
      mask_q  <= '1;
      rdata   <= '0;
    end else begin
      if (wr_sense) sense_q <= wdata & SENSE_KEEP;
      if (wr_prio)  prio_q  <= wdata & PRIO_KEEP;
      pend_q <= (pend_q & keep_vec) | evt;
      mask_q <= (mask_q & ~mclr_vec) | mset_vec;
      if (rd_en) rdata <= rd_mux;
    end
  end

  assign mask_vec = mask_q;
  assign pend_vec = pend_q;
endmodule

// File: rtl/extint_pin_ctrl.sv
module extint_pin_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int PRIO_W   = 4,
  parameter int SRC_W    = 8,
  parameter int ADDR_W   = 3,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] irq_out,
  output logic              irq_any
);
  logic [NUM_PINS*SENSE_W-1:0] sense_fld;
  logic [NUM_PINS-1:0] evt_vec, prio_on, mask_vec, pend_vec;
  logic [NUM_PINS-1:0] keep_vec, mset_vec, mclr_vec;
  logic                src_wr;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    logic lvl, rise, fall;
    extint_sync #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst(rst), .pin(pin_in[n]),
      .lvl(lvl), .rise(rise), .fall(fall)
    );
    extint_detect #(.SW(SENSE_W)) u_det (
      .code(sense_fld[n*SENSE_W +: SENSE_W]),
      .lvl(lvl), .rise(rise), .fall(fall), .evt(evt_vec[n])
    );
  end

  extint_regs #(
    .NP(NUM_PINS), .SW(SENSE_W), .PW(PRIO_W), .SRCW(SRC_W), .AW(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr_en), .rd_en(bus_rd_en), .addr(bus_addr), .wdata(bus_wdata),
    .evt(evt_vec), .rdata(bus_rdata),
    .sense_fld(sense_fld), .prio_on(prio_on), .mask_vec(mask_vec),
    .pend_vec(pend_vec), .src_wr(src_wr), .keep_vec(keep_vec),
    .mset_vec(mset_vec), .mclr_vec(mclr_vec)
  );

  assign irq_out = pend_vec & ~mask_vec & prio_on;
  assign irq_any = |irq_out;
endmodule

// File: rtl/extint_pin_ctrl_chk.sv
module extint_pin_ctrl_chk #(
  parameter int NP = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [NP-1:0] irq_out,
  input logic [NP-1:0] mask_vec,
  input logic [NP-1:0] prio_on,
  input logic [NP-1:0] pend_vec,
  input logic [NP-1:0] evt_vec,
  input logic          src_wr,
  input logic [NP-1:0] keep_vec,
  input logic [NP-1:0] mset_vec,
  input logic [NP-1:0] mclr_vec
);
  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    (irq_out & mask_vec) == '0);

  a_r7_prio_zero_blocks: assert property (@(posedge clk) disable iff (rst)
    (irq_out & ~prio_on) == '0);

  a_r10_out_needs_pending: assert property (@(posedge clk) disable iff (rst)
    (irq_out & ~pend_vec) == '0);

  a_r3_event_latches: assert property (@(posedge clk) disable iff (rst)
    (evt_vec != '0) |=> (($past(evt_vec) & ~pend_vec) == '0));

  a_r8_zero_write_clears: assert property (@(posedge clk) disable iff (rst)
    (src_wr && ((~keep_vec & ~evt_vec) != '0)) |=>
      (($past(~keep_vec & ~evt_vec) & pend_vec) == '0));

  a_r4_no_spurious_pending: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_vec & ~$past(pend_vec) & ~$past(evt_vec)) == '0));

  a_r9_mask_set: assert property (@(posedge clk) disable iff (rst)
    (mset_vec != '0) |=> (($past(mset_vec) & ~mask_vec) == '0));

  a_r9_mask_clear: assert property (@(posedge clk) disable iff (rst)
    (mclr_vec != '0) |=> (($past(mclr_vec) & mask_vec) == '0));
endmodule

bind extint_pin_ctrl extint_pin_ctrl_chk #(.NP(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .irq_out(irq_out), .mask_vec(mask_vec),
  .prio_on(prio_on), .pend_vec(pend_vec), .evt_vec(evt_vec),
  .src_wr(src_wr), .keep_vec(keep_vec), .mset_vec(mset_vec),
  .mclr_vec(mclr_vec)
);

// File: tb/test_extint_pin_ctrl.sv
`timescale 1ns/1ps
module test_extint_pin_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pins = '0;
  logic [7:0]  irq_out;
  logic        irq_any;

  int n_checks = 0;
  int n_err = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;  // 250 MHz

  extint_pin_ctrl i_extint_pin_ctrl (
    .clk(clk), .rst(rst), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .pin_in(pins), .irq_out(irq_out), .irq_any(irq_any)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_sense, m_prio, m_rdata;
  bit        m_pend[8], m_mask[8];
  bit        h_first[8], h_sync[8], h_old[8];

  function automatic bit m_event(int code, bit cur, bit old);
    case (code)
      0: return old && !cur;
      1: return cur && !old;
      2: return !cur;
      3: return cur;
      4: return cur != old;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int nib(bit [31:0] r, int pin);
    return int'((r >> (28 - 4 * pin)) & 32'hF);
  endfunction

  function automatic bit [7:0] m_irq();
    bit [7:0] e;
    for (int k = 0; k < 8; k++)
      e[k] = m_pend[k] && !m_mask[k] && (nib(m_prio, k) != 0);
    return e;
  endfunction

  function automatic bit [31:0] m_read(int a);
    bit [31:0] v = 0;
    if (a == 0) v = m_sense;
    else if (a == 1) v = m_prio;
    else if (a == 2) for (int k = 0; k < 8; k++) if (m_pend[k]) v |= 32'h80 >> k;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sense = 0; m_prio = 0; m_rdata = 0;
      for (int k = 0; k < 8; k++) begin
        m_pend[k] = 0; m_mask[k] = 1; h_first[k] = 0; h_sync[k] = 0; h_old[k] = 0;
      end
    end else begin
      bit ev[8];
      for (int k = 0; k < 8; k++) ev[k] = m_event(nib(m_sense, k), h_sync[k], h_old[k]);
      if (rd_en) m_rdata = m_read(int'(addr));
      for (int k = 0; k < 8; k++) begin
        if (wr_en && addr == 3'd2 && !wdata[7-k]) m_pend[k] = 0;
        if (ev[k]) m_pend[k] = 1;
        if (wr_en && addr == 3'd3 && wdata[7-k]) m_mask[k] = 1;
        if (wr_en && addr == 3'd4 && wdata[7-k]) m_mask[k] = 0;
      end
      if (wr_en && addr == 3'd0) m_sense = wdata;
      if (wr_en && addr == 3'd1) m_prio = wdata;
      for (int k = 0; k < 8; k++) begin
        h_old[k] = h_sync[k]; h_sync[k] = h_first[k]; h_first[k] = pins[k];
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (!rst) begin
      check("R10 irq_out vs model", 32'(irq_out), 32'(m_irq()));
      check("R10 irq_any vs model", 32'(irq_any), 32'(|m_irq()));
      check("R11 bus_rdata vs model", rdata, m_rdata);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic edges(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    edges(3);
    rst = 1'b0;
    edges(1);
    // R1 reset state
    check("R1 irq_out after reset", 32'(irq_out), 32'h0);
    check("R1 bus_rdata after reset", rdata, 32'h0);
    bus_read(3'd0, rv); check("R1 sense reset", rv, 32'h0);
    bus_read(3'd1, rv); check("R1 prio reset", rv, 32'h0);
    bus_read(3'd2, rv); check("R1 source reset", rv, 32'h0);
    bus_read(3'd3, rv); check("R9 mask-set reads zero", rv, 32'h0);
    bus_read(3'd4, rv); check("R9 mask-clear reads zero", rv, 32'h0);
    bus_read(3'd7, rv); check("R11 unmapped read zero", rv, 32'h0);

    pins = 8'b0000_1000;  // pin3 idles high for its low-level sense
    edges(4);
    bus_write(3'd1, 32'hFFFF_FFFF);
    bus_read(3'd1, rv); check("R7 prio readback", rv, 32'hFFFF_FFFF);
    // pins 0..7: rise, fall, high, low, both, code9, rise, rise
    bus_write(3'd0, 32'h1032_4911);
    bus_read(3'd0, rv); check("R6 sense readback", rv, 32'h1032_4911);
    bus_write(3'd2, 32'h0);
    bus_write(3'd4, 32'hFF);
    check("R9 unmasked with nothing pending", 32'(irq_out), 32'h0);

    // R2 latency on pin0 rising edge
    pins[0] = 1'b1;
    edges(2); check("R2 no irq after two edges", 32'(irq_out[0]), 32'h0);
    edges(1); check("R2 irq on third edge", 32'(irq_out[0]), 32'h1);
    bus_read(3'd2, rv); check("R8 pin0 at source bit 7", rv, 32'h80);
    bus_write(3'd2, 32'h7F);
    check("R8 zero bit clears pin0", 32'(irq_out[0]), 32'h0);
    pins[0] = 1'b0; edges(4);
    check("R3 falling edge ignored in rise mode", 32'(irq_out[0]), 32'h0);

    // R3 falling mode on pin1
    pins[1] = 1'b1; edges(4);
    check("R3 rising edge ignored in fall mode", 32'(irq_out[1]), 32'h0);
    pins[1] = 1'b0; edges(4);
    check("R3 falling edge latched", 32'(irq_out[1]), 32'h1);
    bus_write(3'd2, 32'hBF);
    check("R8 ones keep other flags", 32'(irq_out), 32'h0);

    // R3 both edges on pin4
    pins[4] = 1'b1; edges(4);
    check("R3 both-edge rise", 32'(irq_out[4]), 32'h1);
    bus_write(3'd2, 32'hF7);
    check("R8 clear pin4", 32'(irq_out[4]), 32'h0);
    pins[4] = 1'b0; edges(4);
    check("R3 both-edge fall", 32'(irq_out[4]), 32'h1);
    bus_write(3'd2, 32'hF7);

    // R5 unused code on pin5
    pins[5] = 1'b1; edges(4);
    pins[5] = 1'b0; edges(4);
    check("R5 code 9 never pends", 32'(irq_out[5]), 32'h0);

    // R4 high level on pin2
    pins[2] = 1'b1; edges(4);
    check("R4 high level pends", 32'(irq_out[2]), 32'h1);
    bus_write(3'd2, 32'hDF);
    check("R4 clear ignored while level active", 32'(irq_out[2]), 32'h1);
    pins[2] = 1'b0; edges(4);
    check("R4 flag held after level drops", 32'(irq_out[2]), 32'h1);
    bus_write(3'd2, 32'hDF);
    check("R4 clear after level gone", 32'(irq_out[2]), 32'h0);

    // R4 low level on pin3
    pins[3] = 1'b0; edges(4);
    check("R4 low level pends", 32'(irq_out[3]), 32'h1);
    pins[3] = 1'b1; edges(4);
    bus_write(3'd2, 32'hEF);
    check("R4 low level cleared", 32'(irq_out[3]), 32'h0);

    // R9 masking on pin0
    pins[0] = 1'b1; edges(4);
    check("R10 irq_any follows pin0", 32'(irq_any), 32'h1);
    bus_write(3'd3, 32'h80);
    check("R9 mask-set hides pin0", 32'(irq_out[0]), 32'h0);
    check("R10 irq_any low when masked", 32'(irq_any), 32'h0);
    bus_read(3'd2, rv); check("R9 pending kept under mask", rv & 32'h80, 32'h80);
    bus_write(3'd3, 32'h00);
    bus_write(3'd4, 32'h00);
    check("R9 zero writes no effect", 32'(irq_out[0]), 32'h0);
    bus_write(3'd4, 32'h80);
    check("R9 mask-clear restores pin0", 32'(irq_out[0]), 32'h1);

    // R7 zero priority blocks
    bus_write(3'd1, 32'h0FFF_FFFF);
    check("R7 zero prio blocks pin0", 32'(irq_out[0]), 32'h0);
    bus_read(3'd1, rv); check("R7 prio field readback", rv, 32'h0FFF_FFFF);
    bus_write(3'd1, 32'h1000_0000);
    check("R7 nonzero prio passes", 32'(irq_out[0]), 32'h1);
    bus_write(3'd2, 32'h7F);
    check("R8 pin0 cleared", 32'(irq_out), 32'h0);

    // R6 read-modify-write of pin7's field
    bus_read(3'd0, rv);
    bus_write(3'd0, (rv & ~32'hF) | 32'h4);
    bus_read(3'd0, rv); check("R6 pin7 field rmw", rv, 32'h1032_4914);

    // R11 unmapped write
    bus_write(3'd6, 32'h0);
    bus_read(3'd0, rv); check("R11 sense unchanged", rv, 32'h1032_4914);
    bus_read(3'd1, rv); check("R11 prio unchanged", rv, 32'h1000_0000);
    bus_read(3'd5, rv); check("R11 address 5 reads zero", rv, 32'h0);
    edges(2);
    check("R11 rdata holds without read", rdata, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule